// File: doc/BRIEF.md
# Coprocessor Memory Read Engine

This block sits on the host side of a coprocessor link and moves words out of the coprocessor's memory into a 16-entry read queue. The host uses a small register window. It first writes a 16-bit start address. It then writes a control word that picks the memory space, the burst length, whether the address advances, and a start bit. The engine then issues single-word reads on a plain request/valid memory port and queues each returned word. The host drains the queue by reading the data register.

Three more functions share the control word. A free-running mode keeps fetching until the host stops it, and it pauses whenever the queue is full. A coprocessor reset bit drives a stretched reset output. Two enable bits gate a level interrupt.

The register window has four slots, selected by `reg_addr_i`:

| Select | Register | Access |
|---|---|---|
| 0 | data | read pops the queue |
| 1 | start address | read/write |
| 2 | control | read/write |
| 3 | status | read-only |

Top module: `mre_read_engine`

## Requirements
- R1: The queue holds 16 words in arrival order. A read of select 0 returns the oldest word and removes it. Status bit 6 is 1 while the queue holds a word. Status bit 5 is 1 while it holds 16.
- R2: Control bits 3:2 give the burst length: 0 gives 1 word, 1 gives 8, 2 gives 16, and 3 gives free-running.
- R3: With control bit 1 set, word k of a burst is read from start address + k, wrapping modulo 2^16. With bit 1 clear, every word is read from the start address.
- R4: Control bits 15:12, latched at start, are driven on `mem_sel_o` with every request: 0 selects data memory, 1 the register space and 5 program memory.
- R5: Status bit 0 reads 1 from the start until the last word has been queued and no read is outstanding. Control bit 4 reads back as 1 while the transfer is active.
- R6: In free-running mode, fetching pauses while the queue is full and resumes after a pop. Writing the control word with bit 4 clear ends the run without losing or reordering queued words.
- R7: A data read while the queue is empty returns the last word popped (0 after reset) and leaves the queue empty and intact.
- R8: `irq_o` is 1 exactly when (control bit 5 and the queue is full) or (control bit 6 and the queue is not empty), as a level.
- R9: Control bit 0 drives `cop_rst_o` and status bit 2. After the bit clears, the output stays high for 8 further clock edges and falls on the 9th.
- R10: While `cop_rst_o` is high, the queue is flushed, any transfer is abandoned, start writes are ignored and no memory request is issued.
- R11: At most one memory read is outstanding, and no request is issued while the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (a read of select 0 pops the queue) |
| reg_addr_i | input | 2 | Register select: 0 data, 1 start address, 2 control, 3 status |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the current select |
| irq_o | output | 1 | Level interrupt |
| cop_rst_o | output | 1 | Stretched coprocessor reset |
| mem_req_o | output | 1 | One-cycle word read request |
| mem_sel_o | output | 4 | Memory space of the request |
| mem_addr_o | output | 16 | Word address of the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data |

## Verification
Timing of results:

- A start write takes effect at the edge that samples it.
- The first request follows on the next edge.
- Each returned word is queued at the edge that samples `mem_rvalid_i`, so status and interrupt are due one edge after that.
- Register reads and the data-register head are combinational and are sampled a moment after the driving negative edge, before the popping edge.
- The reset stretch is counted edge by edge from the write that clears the bit. The output is checked still high after the 8th edge and low after the 9th.

Burst results depend on memory latency. The bench therefore polls the busy flag with a bound and only then compares every popped word against an arithmetic model of memory contents, address and space.

// File: rtl/mre_pkg.sv
package mre_pkg;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CFG  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CFG_RST   = 0;
  localparam int CFG_INC   = 1;
  localparam int CFG_LEN   = 2;
  localparam int CFG_START = 4;
  localparam int CFG_IEFUL = 5;
  localparam int CFG_IENE  = 6;
  localparam int CFG_SPACE = 12;

  localparam int ST_BUSY = 0;
  localparam int ST_RST  = 2;
  localparam int ST_FULL = 5;
  localparam int ST_NE   = 6;

  typedef enum logic [1:0] {
    LEN_ONE     = 2'd0,
    LEN_EIGHT   = 2'd1,
    LEN_SIXTEEN = 2'd2,
    LEN_FREE    = 2'd3
  } len_e;
endpackage

// File: rtl/mre_fifo.sv
module mre_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + PW'(1);
      if (pop_ok)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + PW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + (PW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (PW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mre_rst_hold.sv
module mre_rst_hold #(
  parameter int HOLD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_req_i,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (rst_req_i)       cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign rst_o = rst_req_i || (cnt_q != '0);
endmodule

// File: rtl/mre_fetch.sv
module mre_fetch
  import mre_pkg::*;
#(
  parameter int AW       = 16,
  parameter int SW       = 4,
  parameter int DW       = 16,
  parameter int MID_LEN  = 8,
  parameter int LONG_LEN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [1:0]    len_i,
  input  logic          inc_i,
  input  logic [SW-1:0] space_i,
  input  logic          room_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic [SW-1:0] sel_o,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          active_o,
  output logic          pending_o
);
  localparam int CW = $clog2(LONG_LEN + 1);

  logic          active_q, pending_q, req_q, free_q, inc_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] sel_q;
  logic [CW-1:0] left_q, left_init;

  always_comb begin
    case (len_e'(len_i))
      LEN_ONE:     left_init = CW'(1);
      LEN_EIGHT:   left_init = CW'(MID_LEN);
      LEN_SIXTEEN: left_init = CW'(LONG_LEN);
      default:     left_init = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      pending_q <= 1'b0;
      req_q     <= 1'b0;
      free_q    <= 1'b0;
      inc_q     <= 1'b0;
      addr_q    <= '0;
      sel_q     <= '0;
      left_q    <= '0;
    end else begin
      req_q <= 1'b0;
      if (abort_i) begin
        active_q <= 1'b0;
      end else if (start_i && !active_q && !pending_q) begin
        active_q <= 1'b1;
        addr_q   <= base_addr_i;
        sel_q    <= space_i;
        inc_q    <= inc_i;
        free_q   <= (len_e'(len_i) == LEN_FREE);
        left_q   <= left_init;
      end else if (active_q && !pending_q && room_i) begin
        req_q     <= 1'b1;
        pending_q <= 1'b1;
      end
      // late data after an abort is dropped, only the outstanding flag clears
      if (rvalid_i && pending_q) begin
        pending_q <= 1'b0;
        if (active_q && !abort_i) begin
          if (inc_q) addr_q <= addr_q + AW'(1);
          if (!free_q) begin
            left_q <= left_q - CW'(1);
            if (left_q == CW'(1)) active_q <= 1'b0;
          end
        end
      end
    end
  end

  assign req_o       = req_q;
  assign addr_o      = addr_q;
  assign sel_o       = sel_q;
  assign push_o      = rvalid_i && pending_q && active_q && !abort_i;
  assign push_data_o = rdata_i;
  assign active_o    = active_q;
  assign pending_o   = pending_q;
endmodule

// File: rtl/mre_read_engine.sv
module mre_read_engine
  import mre_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter int SW       = 4,
  parameter int DEPTH    = 16,
  parameter int RST_HOLD = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [15:0]   reg_wdata_i,
  output logic [15:0]   reg_rdata_o,
  output logic          irq_o,
  output logic          cop_rst_o,
  output logic          mem_req_o,
  output logic [SW-1:0] mem_sel_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [15:0]   cfg_q, cfg_rd, status;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] last_q, fifo_head, push_data;
  logic          cfg_we, start, abort, pop;
  logic          fifo_empty, fifo_full, push;
  logic          eng_active, eng_pending;

  assign cfg_we = reg_we_i && (reg_addr_i == SEL_CFG);
  assign start  = cfg_we && reg_wdata_i[CFG_START] && !reg_wdata_i[CFG_RST] && !cop_rst_o;
  assign abort  = (cfg_we && (reg_wdata_i[CFG_RST] || !reg_wdata_i[CFG_START])) || cop_rst_o;
  assign pop    = reg_re_i && (reg_addr_i == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
      last_q <= '0;
    end else begin
      if (cfg_we) begin
        cfg_q            <= reg_wdata_i;
        cfg_q[CFG_START] <= 1'b0;
      end
      if (reg_we_i && (reg_addr_i == SEL_ADDR)) addr_q <= reg_wdata_i[AW-1:0];
      if (pop && !fifo_empty) last_q <= fifo_head;
    end
  end

  mre_rst_hold #(.HOLD(RST_HOLD)) u_rst_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_req_i (cfg_q[CFG_RST]),
    .rst_o     (cop_rst_o)
  );

  mre_fetch #(
    .AW       (AW),
    .SW       (SW),
    .DW       (DW),
    .MID_LEN  (8),
    .LONG_LEN (DEPTH)
  ) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .abort_i     (abort),
    .base_addr_i (addr_q),
    .len_i       (reg_wdata_i[CFG_LEN+1:CFG_LEN]),
    .inc_i       (reg_wdata_i[CFG_INC]),
    .space_i     (reg_wdata_i[CFG_SPACE+SW-1:CFG_SPACE]),
    .room_i      (!fifo_full),
    .rvalid_i    (mem_rvalid_i),
    .rdata_i     (mem_rdata_i),
    .req_o       (mem_req_o),
    .addr_o      (mem_addr_o),
    .sel_o       (mem_sel_o),
    .push_o      (push),
    .push_data_o (push_data),
    .active_o    (eng_active),
    .pending_o   (eng_pending)
  );

  mre_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (cop_rst_o),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (fifo_head),
    .empty_o     (fifo_empty),
    .full_o      (fifo_full)
  );

  always_comb begin
    status          = '0;
    status[ST_BUSY] = eng_active || eng_pending;
    status[ST_RST]  = cop_rst_o;
    status[ST_FULL] = fifo_full;
    status[ST_NE]   = !fifo_empty;
    cfg_rd            = cfg_q;
    cfg_rd[CFG_START] = eng_active;
  end

  always_comb begin
    case (reg_addr_i)
      SEL_DATA: reg_rdata_o = 16'(fifo_empty ? last_q : fifo_head);
      SEL_ADDR: reg_rdata_o = 16'(addr_q);
      SEL_CFG:  reg_rdata_o = cfg_rd;
      default:  reg_rdata_o = status;
    endcase
  end

  assign irq_o = (cfg_q[CFG_IEFUL] && fifo_full) || (cfg_q[CFG_IENE] && !fifo_empty);
endmodule

// File: rtl/mre_read_engine_chk.sv
module mre_read_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        irq_o,
  input logic        cop_rst_o,
  input logic [15:0] cfg_q,
  input logic        fifo_full,
  input logic        fifo_empty
);
  // R11
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R11
  no_req_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full |-> !mem_req_o);

  // R1
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full && fifo_empty));

  // R10
  no_req_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_rst_o |-> !mem_req_o);

  // R8
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_q[5] || cfg_q[6]) |-> !irq_o);

  // R9
  rst_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_q[0]) |-> cop_rst_o);
endmodule

bind mre_read_engine mre_read_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .irq_o      (irq_o),
  .cop_rst_o  (cop_rst_o),
  .cfg_q      (cfg_q),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty)
);

// File: tb/mre_read_engine_bench.sv
`timescale 1ns/1ps
module mre_read_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, cop_rst, mreq, rvalid;
  logic [3:0]  msel;
  logic [15:0] maddr, mrdata;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  mre_read_engine u_mre_read_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .cop_rst_o(cop_rst),
    .mem_req_o(mreq), .mem_sel_o(msel), .mem_addr_o(maddr),
    .mem_rvalid_i(rvalid), .mem_rdata_i(mrdata)
  );

  function automatic logic [15:0] mem_word(input logic [3:0] s, input logic [15:0] a);
    return (a ^ 16'hA5C3) + {s, 12'h000};
  endfunction

  // memory model: one cycle of latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      mrdata <= '0;
    end else begin
      rvalid <= mreq;
      mrdata <= mem_word(msel, maddr);
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); sel = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); sel = a; re = 1'b1; #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(2'd3, s);
      if (!s[0]) break;
    end
  endtask

  task automatic wait_full();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(2'd3, s);
      if (s[5]) break;
    end
  endtask

  function automatic logic [15:0] cfgw(input logic [3:0] s, input logic ien, input logic ief,
                                       input logic st, input logic [1:0] len, input logic inc);
    return {s, 5'd0, ien, ief, st, len, inc, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, base;
    logic [3:0]  spaces [3];
    int          n;
    spaces[0] = 4'd0; spaces[1] = 4'd1; spaces[2] = 4'd5;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(2'd3, v); check("R5 reset status", v, 16'h0000);
    rd(2'd0, v); check("R7 reset data", v, 16'h0000);
    check("R8 reset irq", {15'd0, irq}, 16'd0);
    check("R9 reset cop_rst", {15'd0, cop_rst}, 16'd0);

    // sweep: space x length x increment
    for (int si = 0; si < 3; si++) begin
      for (int len = 0; len < 3; len++) begin
        for (int inc = 0; inc < 2; inc++) begin
          base = 16'hFFF6 + 16'(si * 7 + len * 3 + inc);
          n = (len == 0) ? 1 : (len == 1) ? 8 : 16;
          wr(2'd1, base);
          wr(2'd2, cfgw(spaces[si], 1'b0, 1'b0, 1'b1, 2'(len), inc[0]));
          rd(2'd3, v); check("R5 busy during burst", {15'd0, v[0]}, 16'd1);
          wait_idle();
          rd(2'd3, v);
          check("R1 status after burst", v, (n == 16) ? 16'h0060 : 16'h0040);
          for (int k = 0; k < n; k++) begin
            rd(2'd0, v);
            check("R2 R3 R4 burst word", v,
                  mem_word(spaces[si], base + ((inc != 0) ? 16'(k) : 16'd0)));
          end
          rd(2'd3, v); check("R2 drained after length", v, 16'h0000);
        end
      end
    end

    // free-running with stall and stop
    wr(2'd1, 16'h0200);
    wr(2'd2, cfgw(4'd1, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1));
    rd(2'd2, v); check("R5 start bit readback", {15'd0, v[4]}, 16'd1);
    wait_full();
    repeat (10) @(posedge clk);
    rd(2'd3, v); check("R6 stalled while full", v, 16'h0061);
    for (int k = 0; k < 4; k++) begin
      rd(2'd0, v); check("R6 free-run word", v, mem_word(4'd1, 16'h0200 + 16'(k)));
    end
    wait_full();
    wr(2'd2, cfgw(4'd1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1));
    wait_idle();
    rd(2'd3, v); check("R6 stopped and full", v, 16'h0060);
    for (int k = 4; k < 20; k++) begin
      rd(2'd0, v); check("R6 resumed word", v, mem_word(4'd1, 16'h0200 + 16'(k)));
    end

    // empty reads
    rd(2'd0, v); check("R7 empty read keeps last", v, mem_word(4'd1, 16'h0213));
    rd(2'd0, v); check("R7 second empty read", v, mem_word(4'd1, 16'h0213));
    rd(2'd3, v); check("R7 still empty", v, 16'h0000);
    wr(2'd1, 16'h0040);
    wr(2'd2, cfgw(4'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0));
    wait_idle();
    rd(2'd0, v); check("R7 queue intact after empty reads", v, mem_word(4'd0, 16'h0040));

    // interrupts
    wr(2'd2, cfgw(4'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0));
    wait_idle();
    check("R8 irq on not-empty", {15'd0, irq}, 16'd1);
    rd(2'd0, v);
    #2 check("R8 irq clears on empty", {15'd0, irq}, 16'd0);
    wr(2'd2, cfgw(4'd0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1));
    wait_idle();
    check("R8 irq on full", {15'd0, irq}, 16'd1);
    rd(2'd0, v);
    #2 check("R8 irq clears below full", {15'd0, irq}, 16'd0);
    for (int k = 1; k < 16; k++) rd(2'd0, v);

    // coprocessor reset: flush, stretch, ignored start
    wr(2'd2, cfgw(4'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0));
    wait_idle();
    rd(2'd3, v); check("R10 word queued before reset", {15'd0, v[6]}, 16'd1);
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0000);
    repeat (7) @(posedge clk);
    #1 check("R9 held after 8th edge", {15'd0, cop_rst}, 16'd1);
    @(posedge clk);
    #1 check("R9 released on 9th edge", {15'd0, cop_rst}, 16'd0);
    rd(2'd3, v); check("R10 flushed after reset", v, 16'h0000);
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0000);
    wr(2'd2, cfgw(4'd0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1));
    repeat (20) @(posedge clk);
    rd(2'd3, v); check("R10 start ignored in reset", v, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule